// File: doc/BRIEF.md
# Exclusive-Capable Load/Store Execution Unit

This block takes one 32-bit load/store instruction word at a time from a 64-bit RISC pipeline and runs it against a single-request memory port. The word is decoded into an operation, an access size, register indices and an offset form. Each memory request carries an attribute vector. This vector tells the memory system whether the access reads or writes, whether it carries acquire or release ordering, and whether it is part of an exclusive pair. Register operands come in from the pipeline's register read stage. Results, and the status of a store-exclusive, go back out on a single writeback channel. The block keeps its own program counter and steps it by 4 as each legal instruction completes.

A one-entry exclusive monitor records the address and size of the last load-exclusive. A later store-exclusive to the same address and size succeeds: it writes memory and returns status 0. Otherwise it returns status 1 and issues no memory request at all. Every store-exclusive empties the monitor, whether it succeeds or fails. An external clear input, used for a snoop hit or a context switch, also empties it. Encodings that do not decode raise a one-cycle illegal flag and leave all state alone.

Top module: `lsx_unit`

## Requirements
- R1: Immediate-offset form `size,111001,opc,imm12,Rn,Rt` forms its address as Xn plus the 12-bit immediate, zero-extended and not scaled by size. opc 01 is a load, opc 00 is a store, and opc 10 or 11 is illegal.
- R2: Register-offset form `size,111000,opc,1,Rm,option,S,10,Rn,Rt` forms its address as Xn plus Xm. It is legal only with option 011 and S 0, and only with opc 01 (load) or opc 00 (store). Every other combination is illegal.
- R3: Size code s transfers 2^s bytes. Write strobes mark 2^s consecutive byte lanes starting at lane addr[2:0], and the write data carries Xt's low bytes in those lanes. A load returns the same lanes of the read word, zero-extended to 64 bits, to register Rt.
- R4: The request attribute vector has these bits: bit0 read, bit1 write, bit2 sequentially consistent acquire (acquire and not rcpc), bit3 processor-consistent acquire (acquire and rcpc), bit4 release, bit5 exclusive. The load-acquire word `size,001000,1,1,0,11111,1,11111,Rn,Rt` sets bit2. The rcpc load-acquire word `size,111000,10,1,11111,1100,00,Rn,Rt` sets bit3. The store-release word (bit 22 = 0) sets bit4. All three use a zero offset.
- R5: Load-exclusive `size,001000,0,1,0,11111,A,11111,Rn,Rt` reads at Xn with zero offset. It sets bit5, and also bit2 when A is 1. On completion it arms the monitor with its address and size.
- R6: Store-exclusive `size,001000,0,0,0,Rs,L,11111,Rn,Rt` succeeds only when the monitor is armed with the same address and size. On success it issues a write with bits 1 and 5 set (plus bit4 when L is 1), and on completion it writes 0 to register Rs.
- R7: A failing store-exclusive issues no memory request. One cycle after acceptance it writes 1 to Rs and steps the program counter by 4.
- R8: Every store-exclusive, successful or not, disarms the monitor, so a repeat of it fails.
- R9: A one-cycle pulse on `clr_monitor` disarms the monitor, so a following store-exclusive fails.
- R10: An illegal word raises `illegal` for exactly one cycle. It issues no request, performs no writeback and leaves the program counter unchanged.
- R11: After reset the unit is idle with the program counter at RESET_PC. A request stays valid with a stable address until it is accepted. `busy` stays high from acceptance until the response. Every legal instruction steps the program counter by exactly 4.
- R12: An ordinary store always issues its write, performs no register writeback, and steps the program counter by 4 once the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction offered; taken when `busy` is low |
| insn | input | 32 | Instruction word |
| opnd_base | input | XLEN | Value of register Rn |
| opnd_index | input | XLEN | Value of register Rm |
| opnd_store | input | XLEN | Value of register Rt (store data) |
| clr_monitor | input | 1 | Disarms the exclusive monitor |
| busy | output | 1 | Memory access in progress |
| illegal | output | 1 | One-cycle pulse for an undecodable word |
| pc | output | XLEN | Program counter |
| wb_valid | output | 1 | Register writeback strobe |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | XLEN | Writeback value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | XLEN | Byte address |
| mem_req_size | output | 2 | log2 of byte count |
| mem_req_write | output | 1 | Request is a write |
| mem_req_wdata | output | XLEN | Lane-aligned write data |
| mem_req_wstrb | output | XLEN/8 | Byte write strobes |
| mem_req_attr | output | 6 | Access attribute vector (R4) |
| mem_rsp_valid | input | 1 | Response for the accepted request |
| mem_rsp_rdata | input | XLEN | Naturally aligned read word |

## Verification
The illegal flag and the status of a failing store-exclusive appear one clock edge after the edge that accepts the word. A memory request also appears one edge after acceptance. Load data, success status and the program counter step appear one edge after the response edge. The bench drives every stimulus on a falling edge and reads each result at the falling edge that follows the edge where it is due. It holds `mem_req_ready` low for a varied number of cycles before the handshake, which exercises request holding. It also reads `illegal` one further falling edge later to confirm that the pulse lasts a single cycle.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

  typedef enum logic [2:0] {
    OP_BAD   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_LDEX  = 3'd3,
    OP_STEX  = 3'd4
  } lsx_op_e;

  typedef enum logic [1:0] {
    OFS_ZERO = 2'd0,
    OFS_IMM  = 2'd1,
    OFS_REG  = 2'd2
  } lsx_ofs_e;

  // bit0 rd, bit1 wr, bit2 acq_sc, bit3 acq_pc, bit4 rel, bit5 excl
  typedef struct packed {
    logic excl;
    logic rel;
    logic acq_pc;
    logic acq_sc;
    logic wr;
    logic rd;
  } lsx_attr_t;

  typedef struct packed {
    lsx_op_e   op;
    logic [1:0] size;
    logic [4:0] rt;
    logic [4:0] rn;
    logic [4:0] rm;
    logic [4:0] rs;
    lsx_ofs_e  ofs;
    logic [11:0] imm;
    lsx_attr_t attr;
  } lsx_dec_t;

endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
  import lsx_pkg::*;
(
  input  logic [31:0] insn,
  output lsx_dec_t    dec
);

  logic acq, rcpc;

  always_comb begin
    dec      = '0;
    dec.op   = OP_BAD;
    dec.ofs  = OFS_ZERO;
    dec.size = insn[31:30];
    dec.rt   = insn[4:0];
    dec.rn   = insn[9:5];
    dec.rm   = insn[20:16];
    dec.rs   = insn[20:16];
    dec.imm  = insn[21:10];
    acq      = 1'b0;
    rcpc     = 1'b0;

    if (insn[29:24] == 6'b001000 && !insn[23] && !insn[21] &&
        insn[14:10] == 5'h1f) begin
      // exclusive pair
      if (insn[22]) begin
        if (insn[20:16] == 5'h1f) begin
          dec.op        = OP_LDEX;
          acq           = insn[15];
          dec.attr.rd   = 1'b1;
          dec.attr.excl = 1'b1;
        end
      end else begin
        dec.op        = OP_STEX;
        dec.attr.wr   = 1'b1;
        dec.attr.rel  = insn[15];
        dec.attr.excl = 1'b1;
      end
    end else if (insn[29:24] == 6'b001000 && insn[23] && !insn[21] &&
                 insn[20:16] == 5'h1f && insn[15] && insn[14:10] == 5'h1f) begin
      // ordered, zero offset
      if (insn[22]) begin
        dec.op      = OP_LOAD;
        acq         = 1'b1;
        dec.attr.rd = 1'b1;
      end else begin
        dec.op       = OP_STORE;
        dec.attr.wr  = 1'b1;
        dec.attr.rel = 1'b1;
      end
    end else if (insn[29:21] == 9'b111000101 && insn[20:16] == 5'h1f &&
                 insn[15:10] == 6'b110000) begin
      dec.op      = OP_LOAD;
      acq         = 1'b1;
      rcpc        = 1'b1;
      dec.attr.rd = 1'b1;
    end else if (insn[29:24] == 6'b111000 && insn[21] && insn[11:10] == 2'b10) begin
      if (insn[15:13] == 3'b011 && !insn[12]) begin
        dec.ofs = OFS_REG;
        if (insn[23:22] == 2'b01) begin
          dec.op      = OP_LOAD;
          dec.attr.rd = 1'b1;
        end else if (insn[23:22] == 2'b00) begin
          dec.op      = OP_STORE;
          dec.attr.wr = 1'b1;
        end
      end
    end else if (insn[29:24] == 6'b111001) begin
      dec.ofs = OFS_IMM;
      if (insn[23:22] == 2'b01) begin
        dec.op      = OP_LOAD;
        dec.attr.rd = 1'b1;
      end else if (insn[23:22] == 2'b00) begin
        dec.op      = OP_STORE;
        dec.attr.wr = 1'b1;
      end
    end

    dec.attr.acq_sc = acq & ~rcpc;
    dec.attr.acq_pc = acq & rcpc;
  end

endmodule

// File: rtl/lsx_monitor.sv
module lsx_monitor #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          arm,
  input  logic [AW-1:0] arm_addr,
  input  logic [1:0]    arm_size,
  input  logic          consume,
  input  logic [AW-1:0] probe_addr,
  input  logic [1:0]    probe_size,
  output logic          hit
);

  logic          armed;
  logic [AW-1:0] mon_addr;
  logic [1:0]    mon_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      mon_addr <= '0;
      mon_size <= '0;
    end else if (clr || consume) begin
      armed <= 1'b0;
    end else if (arm) begin
      armed    <= 1'b1;
      mon_addr <= arm_addr;
      mon_size <= arm_size;
    end
  end

  assign hit = armed && (mon_addr == probe_addr) && (mon_size == probe_size);

  AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !armed); // R9

  AST_STEX_DISARMS: assert property (@(posedge clk) disable iff (rst)
    consume |=> !armed); // R8

endmodule

// File: rtl/lsx_unit.sv
module lsx_unit
  import lsx_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] RESET_PC = 64'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [31:0]       insn,
  input  logic [XLEN-1:0]   opnd_base,
  input  logic [XLEN-1:0]   opnd_index,
  input  logic [XLEN-1:0]   opnd_store,
  input  logic              clr_monitor,
  output logic              busy,
  output logic              illegal,
  output logic [XLEN-1:0]   pc,
  output logic              wb_valid,
  output logic [4:0]        wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic              mem_req_write,
  output logic [XLEN-1:0]   mem_req_wdata,
  output logic [XLEN/8-1:0] mem_req_wstrb,
  output logic [5:0]        mem_req_attr,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_rdata
);

  localparam int NB = XLEN / 8;
  localparam int OW = $clog2(NB);

  typedef enum logic [1:0] { S_IDLE, S_REQ, S_WAIT } state_e;

  function automatic logic [NB-1:0] lane_mask(input logic [1:0] sz);
    logic [NB-1:0] m;
    for (int i = 0; i < NB; i++) m[i] = (i < (1 << sz));
    return m;
  endfunction

  function automatic logic [XLEN-1:0] lane_extract(input logic [XLEN-1:0] w,
                                                   input logic [1:0] sz,
                                                   input logic [OW-1:0] o);
    logic [XLEN-1:0] s;
    logic [NB-1:0]   m;
    logic [XLEN-1:0] r;
    s = w >> {o, 3'b000};
    m = lane_mask(sz);
    for (int i = 0; i < NB; i++) r[8*i +: 8] = m[i] ? s[8*i +: 8] : 8'h00;
    return r;
  endfunction

  lsx_dec_t        dec;
  state_e          state;
  lsx_op_e         h_op;
  logic [4:0]      h_rt;
  logic [4:0]      h_rs;
  logic [XLEN-1:0] ofs_val;
  logic [XLEN-1:0] eff_addr;
  logic            issue;
  logic            mon_hit;
  logic            mon_arm;
  logic            mon_consume;
  logic            rsp_done;

  lsx_decode u_decode (
    .insn (insn),
    .dec  (dec)
  );

  always_comb begin
    case (dec.ofs)
      OFS_IMM: ofs_val = XLEN'(dec.imm);
      OFS_REG: ofs_val = opnd_index;
      default: ofs_val = '0;
    endcase
  end

  assign eff_addr    = opnd_base + ofs_val;
  assign issue       = (state == S_IDLE) && insn_valid;
  assign rsp_done    = (state == S_WAIT) && mem_rsp_valid;
  assign mon_consume = issue && (dec.op == OP_STEX);
  assign mon_arm     = rsp_done && (h_op == OP_LDEX);

  lsx_monitor #(.AW(XLEN)) u_monitor (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr_monitor),
    .arm        (mon_arm),
    .arm_addr   (mem_req_addr),
    .arm_size   (mem_req_size),
    .consume    (mon_consume),
    .probe_addr (eff_addr),
    .probe_size (dec.size),
    .hit        (mon_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      busy          <= 1'b0;
      illegal       <= 1'b0;
      pc            <= RESET_PC;
      wb_valid      <= 1'b0;
      wb_idx        <= '0;
      wb_data       <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_size  <= '0;
      mem_req_write <= 1'b0;
      mem_req_wdata <= '0;
      mem_req_wstrb <= '0;
      mem_req_attr  <= '0;
      h_op          <= OP_BAD;
      h_rt          <= '0;
      h_rs          <= '0;
    end else begin
      illegal  <= 1'b0;
      wb_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (issue) begin
            if (dec.op == OP_BAD) begin
              illegal <= 1'b1;
            end else if (dec.op == OP_STEX && !mon_hit) begin
              wb_valid <= 1'b1;
              wb_idx   <= dec.rs;
              wb_data  <= XLEN'(1);
              pc       <= pc + XLEN'(4);
            end else begin
              state         <= S_REQ;
              busy          <= 1'b1;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= eff_addr;
              mem_req_size  <= dec.size;
              mem_req_write <= dec.attr.wr;
              mem_req_wdata <= opnd_store << {eff_addr[OW-1:0], 3'b000};
              mem_req_wstrb <= dec.attr.wr ? (lane_mask(dec.size) << eff_addr[OW-1:0]) : '0;
              mem_req_attr  <= dec.attr;
              h_op          <= dec.op;
              h_rt          <= dec.rt;
              h_rs          <= dec.rs;
            end
          end
        end
        S_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            state <= S_IDLE;
            busy  <= 1'b0;
            pc    <= pc + XLEN'(4);
            case (h_op)
              OP_LOAD, OP_LDEX: begin
                wb_valid <= 1'b1;
                wb_idx   <= h_rt;
                wb_data  <= lane_extract(mem_rsp_rdata, mem_req_size, mem_req_addr[OW-1:0]);
              end
              OP_STEX: begin
                wb_valid <= 1'b1;
                wb_idx   <= h_rs;
                wb_data  <= '0;
              end
              default: ;
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11

  AST_REQ_UNDER_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy); // R11

  AST_PC_STEP_FOUR: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> pc == $past(pc) + XLEN'(4)); // R11

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !busy && !wb_valid && $stable(pc)); // R10

  AST_WB_AT_END: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> !busy && !mem_req_valid); // R7

endmodule

// File: tb/test_lsx_unit.sv
`timescale 1ns/1ps
module test_lsx_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        insn_valid;
  logic [31:0] insn;
  logic [63:0] opnd_base, opnd_index, opnd_store;
  logic        clr_monitor;
  logic        busy, illegal, wb_valid;
  logic [63:0] pc, wb_data;
  logic [4:0]  wb_idx;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic [7:0]  mem_req_wstrb;
  logic [5:0]  mem_req_attr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_rdata;

  lsx_unit i_lsx_unit (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn),
    .opnd_base(opnd_base), .opnd_index(opnd_index), .opnd_store(opnd_store),
    .clr_monitor(clr_monitor), .busy(busy), .illegal(illegal), .pc(pc),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
    .mem_req_write(mem_req_write), .mem_req_wdata(mem_req_wdata),
    .mem_req_wstrb(mem_req_wstrb), .mem_req_attr(mem_req_attr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [63:0] bmem [16];

  logic        c_req, c_ill, c_ill2, c_hold, c_busy_mid, c_busy_end, c_wr, c_wb_v;
  logic [63:0] c_addr, c_wdata, c_wb_data, c_pc, pc0;
  logic [1:0]  c_size;
  logic [7:0]  c_strb;
  logic [5:0]  c_attr;
  logic [4:0]  c_wb_idx;

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_imm(input logic [1:0] sz, input logic [1:0] opc,
                                        input logic [11:0] imm, input logic [4:0] rn, input logic [4:0] rt);
    return {sz, 6'b111001, opc, imm, rn, rt};
  endfunction
  function automatic logic [31:0] f_reg(input logic [1:0] sz, input logic [1:0] opc, input logic [4:0] rm,
                                        input logic [2:0] opt, input logic s, input logic [4:0] rn, input logic [4:0] rt);
    return {sz, 6'b111000, opc, 1'b1, rm, opt, s, 2'b10, rn, rt};
  endfunction
  function automatic logic [31:0] f_ldx(input logic [1:0] sz, input logic a, input logic [4:0] rn, input logic [4:0] rt);
    return {sz, 6'b001000, 3'b010, 5'h1f, a, 5'h1f, rn, rt};
  endfunction
  function automatic logic [31:0] f_stx(input logic [1:0] sz, input logic [4:0] rs, input logic l,
                                        input logic [4:0] rn, input logic [4:0] rt);
    return {sz, 6'b001000, 3'b000, rs, l, 5'h1f, rn, rt};
  endfunction

  function automatic logic [63:0] exp_load(input logic [63:0] a, input logic [1:0] sz);
    logic [63:0] w;
    logic [63:0] m;
    w = bmem[a[6:3]] >> (8 * a[2:0]);
    m = (sz == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * (1 << sz))) - 64'd1);
    return w & m;
  endfunction

  function automatic logic [63:0] bytemask(input logic [7:0] s);
    logic [63:0] m;
    for (int b = 0; b < 8; b++) m[8*b +: 8] = s[b] ? 8'hFF : 8'h00;
    return m;
  endfunction

  // entered at a falling edge
  task automatic run(input logic [31:0] w, input logic [63:0] xn, input logic [63:0] xm,
                     input logic [63:0] xt, input int dly);
    pc0 = pc;
    insn = w; opnd_base = xn; opnd_index = xm; opnd_store = xt; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    c_ill = illegal; c_req = mem_req_valid; c_hold = 1'b1; c_busy_mid = 1'b1; c_busy_end = busy;
    c_wb_v = wb_valid; c_wb_idx = wb_idx; c_wb_data = wb_data;
    c_addr = '0; c_wdata = '0; c_size = '0; c_strb = '0; c_attr = '0; c_wr = 1'b0;
    if (c_req) begin
      c_addr = mem_req_addr; c_size = mem_req_size; c_wr = mem_req_write;
      c_wdata = mem_req_wdata; c_strb = mem_req_wstrb; c_attr = mem_req_attr;
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        if (!mem_req_valid || mem_req_addr !== c_addr || !busy) c_hold = 1'b0;
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      if (mem_req_valid || !busy) c_busy_mid = 1'b0;
      if (c_wr)
        for (int b = 0; b < 8; b++)
          if (c_strb[b]) bmem[c_addr[6:3]][8*b +: 8] = c_wdata[8*b +: 8];
      mem_rsp_rdata = bmem[c_addr[6:3]];
      mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      c_wb_v = wb_valid; c_wb_idx = wb_idx; c_wb_data = wb_data; c_busy_end = busy;
    end
    c_pc = pc;
    @(negedge clk);
    c_ill2 = illegal;
  endtask

  task automatic expect_illegal(input string r, input logic [31:0] w);
    run(w, 64'h40, 64'h8, 64'h0, 0);
    chk(r, "illegal pulse", {63'd0, c_ill}, 64'd1);
    chk(r, "no request", {63'd0, c_req}, 64'd0);
    chk(r, "no writeback", {63'd0, c_wb_v}, 64'd0);
    chk(r, "pc unchanged", c_pc, pc0);
    chk("R10", "illegal one cycle", {63'd0, c_ill2}, 64'd0);
  endtask

  task automatic expect_stx_fail(input string r, input logic [31:0] w, input logic [63:0] xn, input logic [4:0] rs);
    run(w, xn, 64'h0, 64'hDEAD_BEEF_0000_1111, 0);
    chk(r, "stx fail no request", {63'd0, c_req}, 64'd0);
    chk(r, "stx fail wb valid", {63'd0, c_wb_v}, 64'd1);
    chk(r, "stx fail status reg", {59'd0, c_wb_idx}, {59'd0, rs});
    chk(r, "stx fail status", c_wb_data, 64'd1);
    chk(r, "stx fail pc", c_pc, pc0 + 64'd4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] e, a, xt;
    logic [11:0] imm;
    rst = 1'b1; insn_valid = 1'b0; insn = '0; opnd_base = '0; opnd_index = '0; opnd_store = '0;
    clr_monitor = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
    for (int i = 0; i < 16; i++) bmem[i] = 64'h0123_4567_89AB_CDEF ^ (64'h1357_9BDF_2468_ACE1 * 64'(i + 1));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11", "reset pc", pc, 64'h1000);
    chk("R11", "reset busy", {63'd0, busy}, 64'd0);
    chk("R11", "reset req", {63'd0, mem_req_valid}, 64'd0);
    chk("R10", "reset illegal", {63'd0, illegal}, 64'd0);
    chk("R11", "reset wb", {63'd0, wb_valid}, 64'd0);

    // R1 R3 immediate loads and stores, every size
    for (int sz = 0; sz < 4; sz++) begin
      for (int k = 0; k < 3; k++) begin
        imm = 12'((1 << sz) * (3 * k + 1));
        a = 64'h40 + 64'(imm);
        e = exp_load(a, 2'(sz));
        run(f_imm(2'(sz), 2'b01, imm, 5'd2, 5'(sz + 1)), 64'h40, 64'h0, 64'h0, (sz + k) % 3);
        chk("R1", "load addr unscaled", c_addr, a);
        chk("R3", "load size", {62'd0, c_size}, 64'(sz));
        chk("R4", "load attr", {58'd0, c_attr}, 64'h01);
        chk("R3", "load data zero-extended", c_wb_data, e);
        chk("R3", "load dest", {59'd0, c_wb_idx}, 64'(sz + 1));
        chk("R11", "request held", {63'd0, c_hold}, 64'd1);
        chk("R11", "busy until response", {63'd0, c_busy_mid}, 64'd1);
        chk("R11", "load pc", c_pc, pc0 + 64'd4);
        xt = 64'hA1B2_C3D4_E5F6_0718 + 64'(sz * 16 + k);
        run(f_imm(2'(sz), 2'b00, imm, 5'd2, 5'd7), 64'h40, 64'h0, xt, k);
        chk("R12", "store issued", {63'd0, c_req}, 64'd1);
        chk("R1", "store addr", c_addr, a);
        chk("R3", "store strobes", {56'd0, c_strb}, 64'((((1 << (1 << sz)) - 1) << a[2:0]) & 8'hFF));
        chk("R3", "store data lanes", c_wdata & bytemask(c_strb), (xt << (8 * a[2:0])) & bytemask(c_strb));
        chk("R4", "store attr", {58'd0, c_attr}, 64'h02);
        chk("R12", "store no writeback", {63'd0, c_wb_v}, 64'd0);
        chk("R12", "store pc", c_pc, pc0 + 64'd4);
      end
    end

    // R1 immediate form with opc 10 / 11
    expect_illegal("R1", f_imm(2'd2, 2'b10, 12'h4, 5'd1, 5'd1));
    expect_illegal("R1", f_imm(2'd2, 2'b11, 12'h4, 5'd1, 5'd1));

    // R2 register form sweep over option, S and opc
    for (int opt = 0; opt < 8; opt++) begin
      for (int s = 0; s < 2; s++) begin
        for (int opc = 0; opc < 4; opc++) begin
          if (opt == 3 && s == 0 && opc < 2) begin
            e = exp_load(64'h50, 2'd2);
            run(f_reg(2'd2, 2'(opc), 5'd3, 3'(opt), 1'(s), 5'd1, 5'd9), 64'h40, 64'h10, 64'h77, 1);
            chk("R2", "reg form accepted", {63'd0, c_ill}, 64'd0);
            chk("R2", "reg form addr", c_addr, 64'h50);
            chk("R2", "reg form write flag", {63'd0, c_wr}, 64'(opc == 0));
            if (opc == 1) chk("R2", "reg form load data", c_wb_data, e);
          end else begin
            expect_illegal("R2", f_reg(2'd2, 2'(opc), 5'd3, 3'(opt), 1'(s), 5'd1, 5'd9));
          end
        end
      end
    end

    // R4 ordered accesses
    e = exp_load(64'h30, 2'd3);
    run({2'd3, 6'b001000, 3'b110, 5'h1f, 1'b1, 5'h1f, 5'd1, 5'd3}, 64'h30, 64'h0, 64'h0, 0);
    chk("R4", "load-acquire attr", {58'd0, c_attr}, 64'h05);
    chk("R4", "load-acquire addr", c_addr, 64'h30);
    chk("R4", "load-acquire data", c_wb_data, e);
    run({2'd2, 6'b111000, 3'b101, 5'h1f, 6'b110000, 5'd1, 5'd3}, 64'h34, 64'h0, 64'h0, 2);
    chk("R4", "rcpc acquire attr", {58'd0, c_attr}, 64'h09);
    chk("R4", "rcpc acquire addr", c_addr, 64'h34);
    run({2'd1, 6'b001000, 3'b100, 5'h1f, 1'b1, 5'h1f, 5'd1, 5'd3}, 64'h22, 64'h0, 64'h5A5A, 1);
    chk("R4", "store-release attr", {58'd0, c_attr}, 64'h12);
    chk("R4", "store-release strobes", {56'd0, c_strb}, 64'h0C);

    // R5 R6 exclusive success, then R8 repeat fails
    e = exp_load(64'h48, 2'd3);
    run(f_ldx(2'd3, 1'b1, 5'd2, 5'd4), 64'h48, 64'h0, 64'h0, 1);
    chk("R5", "ldx attr", {58'd0, c_attr}, 64'h25);
    chk("R5", "ldx addr zero offset", c_addr, 64'h48);
    chk("R5", "ldx data", c_wb_data, e);
    run(f_stx(2'd3, 5'd7, 1'b1, 5'd2, 5'd5), 64'h48, 64'h0, 64'hCAFE_F00D_1234_5678, 2);
    chk("R6", "stx success request", {63'd0, c_req}, 64'd1);
    chk("R6", "stx success attr", {58'd0, c_attr}, 64'h32);
    chk("R6", "stx success strobes", {56'd0, c_strb}, 64'hFF);
    chk("R6", "stx success status reg", {59'd0, c_wb_idx}, 64'd7);
    chk("R6", "stx success status", c_wb_data, 64'd0);
    chk("R6", "stx success pc", c_pc, pc0 + 64'd4);
    expect_stx_fail("R8", f_stx(2'd3, 5'd7, 1'b0, 5'd2, 5'd5), 64'h48, 5'd7);
    e = exp_load(64'h48, 2'd3);
    chk("R7", "failed stx left memory", e, 64'hCAFE_F00D_1234_5678);

    // R6 address mismatch, then R8 cleared by the failure
    run(f_ldx(2'd2, 1'b0, 5'd2, 5'd4), 64'h50, 64'h0, 64'h0, 0);
    chk("R5", "ldx plain attr", {58'd0, c_attr}, 64'h21);
    expect_stx_fail("R6", f_stx(2'd2, 5'd11, 1'b0, 5'd2, 5'd5), 64'h54, 5'd11);
    expect_stx_fail("R8", f_stx(2'd2, 5'd11, 1'b0, 5'd2, 5'd5), 64'h50, 5'd11);

    // R6 size mismatch
    run(f_ldx(2'd3, 1'b0, 5'd2, 5'd4), 64'h58, 64'h0, 64'h0, 0);
    expect_stx_fail("R6", f_stx(2'd2, 5'd12, 1'b0, 5'd2, 5'd5), 64'h58, 5'd12);

    // R9 external clear
    run(f_ldx(2'd2, 1'b0, 5'd2, 5'd4), 64'h60, 64'h0, 64'h0, 0);
    clr_monitor = 1'b1;
    @(negedge clk);
    clr_monitor = 1'b0;
    expect_stx_fail("R9", f_stx(2'd2, 5'd13, 1'b0, 5'd2, 5'd5), 64'h60, 5'd13);
    // R6 control: same pair without clear succeeds
    run(f_ldx(2'd2, 1'b0, 5'd2, 5'd4), 64'h60, 64'h0, 64'h0, 0);
    run(f_stx(2'd2, 5'd13, 1'b0, 5'd2, 5'd5), 64'h60, 64'h0, 64'h0BAD_F00D, 0);
    chk("R6", "stx after ldx succeeds", {63'd0, c_req}, 64'd1);
    chk("R6", "stx success status", c_wb_data, 64'd0);

    // R10 stray words
    expect_illegal("R10", 32'h0000_0000);
    expect_illegal("R10", 32'hFFFF_FFFF);
    expect_illegal("R10", {2'd3, 6'b001000, 3'b010, 5'd0, 1'b0, 5'h1f, 5'd1, 5'd1});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule